// File: doc/BRIEF.md
# Flash Command Sequencer

The block is a register-driven SPI master that runs serial-flash transactions one queued operation at a time. Software loads a 14-bit operation word into a staging register and strobes it into a small operation queue. Each word names an opcode and a byte count. Two opcodes set or release chip select. Three opcodes move data: two shift bytes from the data FIFO out on MOSI, and one captures bytes from MISO into the same FIFO. Software reads received bytes from a head register and pops them with a strobe.

The serial side uses SPI mode 0. SCLK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge, most significant bit first. SCLK runs at the system clock divided by the even parameter `SCLK_DIV`. Operations run only while manual mode is on. Manual mode can be turned on only while the neighbouring read engine reports an idle state of zero. Dummy cycles are sent as 0xFF bytes through an output operation.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0 and mosi_o is 1. Manual mode is off. Both queues are empty, so the status register (address 3) reads 0xA.
- R2: Address 1 is the staging register; it holds the byte count in bits [8:0] and the opcode in bits [13:9], and reads back as written. Writing address 2 with bit 0 set pushes the staged word into the operation queue, which holds OP_DEPTH words. Status bit 0 flags the queue as full, and a push while it is full is dropped.
- R3: Opcode 0x01 drives cs_n_o low and opcode 0x00 drives it high, with no SCLK activity. cs_n_o changes only while sclk_o is low.
- R4: SPI mode 0: sclk_o idles low and has a period of SCLK_DIV system clocks. MOSI changes only on a falling SCLK edge and holds steady while SCLK is high. Bytes go out MSB first.
- R5: Opcodes 0x08 and 0x11 each pop the given number of bytes from the data FIFO and shift them out on mosi_o.
- R6: Opcode 0x0C clocks in the given number of bytes from miso_i, sampled on rising SCLK edges, and pushes them into the data FIFO. MOSI is held high throughout.
- R7: Writing address 4 pushes bits [7:0] into the DAT_DEPTH-entry data FIFO, and address 5 shows its head byte. Writing address 6 with bit 0 set pops the head. Status bit 2 is full and bit 3 is empty. A write while full is dropped, and a pop while empty has no effect.
- R8: Status bit 1 reads 1 only when the operation queue is empty and the engine is idle, i.e. every queued operation has completed.
- R9: Address 0 bit 0 is the manual enable. Writing 1 sets it only when rd_fsm_i is 0, and writing 0 clears it. Address 0 reads the enable in bit 0 and rd_fsm_i in bits [7:4]. Queued operations wait while manual mode is off.
- R10: An operation with any other opcode, or a data operation with a count of 0, is discarded without any pin activity and without touching the data FIFO.
- R11: An output operation waits with SCLK low while the data FIFO is empty, and an input operation waits while it is full. Each resumes once a byte or a slot is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on the address |
| rd_fsm_i | input | 4 | State of the neighbouring read engine; 0 means idle |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Register reads are combinational on the address, and writes take effect at the next clock edge. The bench therefore drives at the falling clock edge and samples 1 ns later: a status or head value is due one edge after the write that caused it. A serial byte takes 8×SCLK_DIV cycles, plus two cycles to fetch and decode the operation and one to load the byte. Rather than counting those cycles, the bench polls status bit 1 (R8) before it checks what a transfer produced. A slave model checks the pin timing on the SCLK edges and measures the SCLK period between the first two rising edges. Stall and gating checks wait a fixed number of cycles that is longer than one byte time. They then confirm that no extra SCLK edges have appeared.

// File: rtl/flash_cmd_seq_pkg.sv
package flash_cmd_seq_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 16;
  localparam int unsigned CNT_W  = 9;
  localparam int unsigned OPC_W  = 5;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_STAGE  = 3'd1;
  localparam logic [REG_AW-1:0] A_PUSH   = 3'd2;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd3;
  localparam logic [REG_AW-1:0] A_DWR    = 3'd4;
  localparam logic [REG_AW-1:0] A_DRD    = 3'd5;
  localparam logic [REG_AW-1:0] A_DPOP   = 3'd6;

  localparam logic [OPC_W-1:0] OPC_CS_HI = 5'h00;
  localparam logic [OPC_W-1:0] OPC_CS_LO = 5'h01;
  localparam logic [OPC_W-1:0] OPC_OUT   = 5'h08;
  localparam logic [OPC_W-1:0] OPC_IN    = 5'h0C;
  localparam logic [OPC_W-1:0] OPC_OUT_A = 5'h11;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [CNT_W-1:0] cnt;
  } op_word_t;

  localparam int unsigned OPW_W = OPC_W + CNT_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_LOAD, ST_LOW, ST_HIGH
  } eng_state_e;
endpackage

// File: rtl/fcs_fifo.sv
module fcs_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= nxt(wptr_q);
      if (do_rd) rptr_q <= nxt(rptr_q);
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import flash_cmd_seq_pkg::*;
#(
  parameter int unsigned DIV  = 4,
  localparam int unsigned HALF = DIV / 2,
  localparam int unsigned TW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       op_valid_i,
  input  op_word_t   op_word_i,
  output logic       op_pop_o,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_pop_o,
  input  logic       rx_ready_i,
  output logic       rx_push_o,
  output logic [7:0] rx_byte_o,
  output logic       idle_o,
  output logic       sclk_o,
  output logic       cs_n_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  eng_state_e       st_q;
  op_word_t         op_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       bit_q;
  logic [TW-1:0]    tmr_q;
  logic [7:0]       tx_sh_q, rx_sh_q;
  logic             is_rx_q, sclk_q, cs_n_q;
  logic             tmr_end;

  assign tmr_end   = (tmr_q == TW'(HALF - 1));
  assign op_pop_o  = (st_q == ST_IDLE) && run_i && op_valid_i;
  assign tx_pop_o  = (st_q == ST_LOAD) && !is_rx_q && tx_valid_i;
  assign rx_push_o = (st_q == ST_HIGH) && tmr_end && (bit_q == 3'd7) && is_rx_q;
  assign rx_byte_o = rx_sh_q;
  assign idle_o    = (st_q == ST_IDLE);
  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_n_q;
  assign mosi_o    = tx_sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      left_q  <= '0;
      bit_q   <= '0;
      tmr_q   <= '0;
      tx_sh_q <= 8'hFF;
      rx_sh_q <= '0;
      is_rx_q <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (op_pop_o) begin
          op_q <= op_word_i;
          st_q <= ST_DECODE;
        end
        ST_DECODE: begin
          left_q <= op_q.cnt;
          st_q   <= ST_IDLE;
          case (op_q.opc)
            OPC_CS_HI: cs_n_q <= 1'b1;
            OPC_CS_LO: cs_n_q <= 1'b0;
            OPC_OUT, OPC_OUT_A: begin
              is_rx_q <= 1'b0;
              if (op_q.cnt != '0) st_q <= ST_LOAD;
            end
            OPC_IN: begin
              is_rx_q <= 1'b1;
              if (op_q.cnt != '0) st_q <= ST_LOAD;
            end
            default: ;  // unknown opcode: dropped
          endcase
        end
        ST_LOAD: begin
          if (is_rx_q ? rx_ready_i : tx_valid_i) begin
            tx_sh_q <= is_rx_q ? 8'hFF : tx_byte_i;
            bit_q   <= '0;
            tmr_q   <= '0;
            st_q    <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmr_end) begin
            tmr_q   <= '0;
            sclk_q  <= 1'b1;
            rx_sh_q <= {rx_sh_q[6:0], miso_i};
            st_q    <= ST_HIGH;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr_end) begin
            tmr_q   <= '0;
            sclk_q  <= 1'b0;
            tx_sh_q <= {tx_sh_q[6:0], 1'b1};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              left_q <= left_q - 1'b1;
              st_q   <= (left_q == CNT_W'(1)) ? ST_IDLE : ST_LOAD;
            end else begin
              st_q <= ST_LOW;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_seq_pkg::*;
#(
  parameter int unsigned OP_DEPTH  = 4,
  parameter int unsigned DAT_DEPTH = 16,
  parameter int unsigned SCLK_DIV  = 4,
  localparam int unsigned OCW = $clog2(OP_DEPTH + 1),
  localparam int unsigned DCW = $clog2(DAT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [3:0]        rd_fsm_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic             manual_q;
  op_word_t         stage_q;
  logic             op_push, op_pop, op_full, op_empty;
  op_word_t         op_head;
  logic [OCW-1:0]   op_cnt;
  logic             sw_dwr, sw_dpop;
  logic             eng_tx_pop, eng_rx_push, eng_idle;
  logic [7:0]       eng_rx_byte;
  logic             dat_push, dat_pop, dat_full, dat_empty;
  logic [7:0]       dat_wdata, dat_head;
  logic [DCW-1:0]   dat_cnt;
  logic             op_done;

  assign op_push = reg_we_i && (reg_addr_i == A_PUSH) && reg_wdata_i[0];
  assign sw_dwr  = reg_we_i && (reg_addr_i == A_DWR);
  assign sw_dpop = reg_we_i && (reg_addr_i == A_DPOP) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      manual_q <= 1'b0;
      stage_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) begin
        if (!reg_wdata_i[0])          manual_q <= 1'b0;
        else if (rd_fsm_i == 4'd0)    manual_q <= 1'b1;
      end
      if (reg_addr_i == A_STAGE) stage_q <= op_word_t'(reg_wdata_i[OPW_W-1:0]);
    end
  end

  fcs_fifo #(.W(OPW_W), .DEPTH(OP_DEPTH)) u_op_q (
    .clk_i, .rst_ni,
    .push_i(op_push), .wdata_i(stage_q),
    .pop_i(op_pop),   .rdata_o(op_head),
    .full_o(op_full), .empty_o(op_empty), .count_o(op_cnt)
  );

  // engine owns the FIFO port it needs for the running op
  assign dat_push  = eng_rx_push | sw_dwr;
  assign dat_wdata = eng_rx_push ? eng_rx_byte : reg_wdata_i[7:0];
  assign dat_pop   = eng_tx_pop | sw_dpop;

  fcs_fifo #(.W(8), .DEPTH(DAT_DEPTH)) u_dat_q (
    .clk_i, .rst_ni,
    .push_i(dat_push), .wdata_i(dat_wdata),
    .pop_i(dat_pop),   .rdata_o(dat_head),
    .full_o(dat_full), .empty_o(dat_empty), .count_o(dat_cnt)
  );

  fcs_engine #(.DIV(SCLK_DIV)) u_eng (
    .clk_i, .rst_ni,
    .run_i(manual_q),
    .op_valid_i(!op_empty), .op_word_i(op_head), .op_pop_o(op_pop),
    .tx_valid_i(!dat_empty), .tx_byte_i(dat_head), .tx_pop_o(eng_tx_pop),
    .rx_ready_i(!dat_full), .rx_push_o(eng_rx_push), .rx_byte_o(eng_rx_byte),
    .idle_o(eng_idle),
    .sclk_o, .cs_n_o, .mosi_o, .miso_i
  );

  assign op_done = op_empty && eng_idle;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {8'b0, rd_fsm_i, 3'b0, manual_q};
      A_STAGE:  reg_rdata_o = REG_DW'(stage_q);
      A_STATUS: reg_rdata_o = {12'b0, dat_empty, dat_full, op_done, op_full};
      A_DRD:    reg_rdata_o = {8'b0, dat_head};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int unsigned OP_DEPTH  = 4,
  parameter int unsigned DAT_DEPTH = 16,
  localparam int unsigned OCW = $clog2(OP_DEPTH + 1),
  localparam int unsigned DCW = $clog2(DAT_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sclk_o,
  input logic           cs_n_o,
  input logic           mosi_o,
  input logic           manual_en,
  input logic [3:0]     rd_fsm_i,
  input logic [OCW-1:0] op_cnt,
  input logic [DCW-1:0] dat_cnt
);
  a_r4_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  a_r3_cs_sclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cs_n_o) |-> (!sclk_o && !$past(sclk_o)));

  a_r9_manual_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(manual_en) |-> ($past(rd_fsm_i) == 4'd0));

  a_r2_op_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_cnt <= OCW'(OP_DEPTH));

  a_r7_dat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_cnt <= DCW'(DAT_DEPTH));
endmodule

bind flash_cmd_seq fcs_checker #(.OP_DEPTH(OP_DEPTH), .DAT_DEPTH(DAT_DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
  .mosi_o(mosi_o), .manual_en(manual_q), .rd_fsm_i(rd_fsm_i),
  .op_cnt(op_cnt), .dat_cnt(dat_cnt)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  localparam int unsigned OPD = 4;
  localparam int unsigned DD  = 16;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  rd_fsm = '0;
  logic        sclk, cs_n, mosi, miso;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] slv_sh = '0;
  logic [7:0]  cap_sh = '0;
  logic [7:0]  cap_q [8];
  int          cap_n = 0, cap_bits = 0, rise_cnt = 0;
  time         t_r1 = 0, t_r2 = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.OP_DEPTH(OPD), .DAT_DEPTH(DD), .SCLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rd_fsm_i(rd_fsm),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // slave model: presents slv_sh MSB, shifts on falling SCLK
  assign miso = slv_sh[15];
  initial forever begin
    @(negedge sclk);
    slv_sh = {slv_sh[14:0], 1'b0};
  end
  initial forever begin
    @(posedge sclk);
    rise_cnt++;
    if (rise_cnt == 1) t_r1 = $time;
    if (rise_cnt == 2) t_r2 = $time;
    if (!cs_n) begin
      cap_sh = {cap_sh[6:0], mosi};
      cap_bits++;
      if (cap_bits == 8) begin
        if (cap_n < 8) cap_q[cap_n] = cap_sh;
        cap_n++;
        cap_bits = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic push_op(input logic [4:0] opc, input logic [8:0] cnt);
    wr(3'd1, {2'b0, opc, cnt});
    wr(3'd2, 16'h1);
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd3, s);
      if (s[1]) return;
    end
    chk("R8 done timeout", 0, 1);
  endtask

  task automatic clr_mon();
    cap_n = 0; cap_bits = 0; rise_cnt = 0; t_r1 = 0; t_r2 = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #1;
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 1);
    rd(3'd3, d); chk("R1 status", d, 16'hA);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_manual_gate();
    logic [15:0] d;
    rd_fsm = 4'd3;
    wr(3'd0, 16'h1);
    rd(3'd0, d); chk("R9 enable blocked", d, 16'h30);
    push_op(5'h01, 9'd1);
    rd(3'd1, d); chk("R2 stage readback", d, 16'h0201);
    repeat (10) @(negedge clk);
    chk("R9 op held while off", cs_n, 1);
    rd(3'd3, d); chk("R8 not done while queued", d[1], 0);
    rd_fsm = 4'd0;
    wr(3'd0, 16'h1);
    rd(3'd0, d); chk("R9 enable accepted", d, 16'h1);
    wait_done();
    chk("R3 cs assert", cs_n, 0);
    push_op(5'h00, 9'd1);
    wait_done();
    chk("R3 cs release", cs_n, 1);
    chk("R3 no sclk on cs ops", sclk, 0);
  endtask

  task automatic t_tx();
    logic [15:0] d;
    push_op(5'h01, 9'd1); wait_done();
    clr_mon();
    wr(3'd4, 16'hA5);
    wr(3'd4, 16'h3C);
    push_op(5'h08, 9'd2);
    wait_done();
    push_op(5'h00, 9'd1); wait_done();
    chk("R5 byte count", cap_n, 2);
    chk("R5 byte0 MSB first", cap_q[0], 8'hA5);
    chk("R5 byte1", cap_q[1], 8'h3C);
    chk("R4 edges", rise_cnt, 16);
    chk("R4 sclk period", 32'(t_r2 - t_r1), 32'(DIV * 4));
    rd(3'd3, d); chk("R7 fifo drained", d, 16'hA);
  endtask

  task automatic t_tx_addr();
    push_op(5'h01, 9'd1); wait_done();
    clr_mon();
    wr(3'd4, 16'h0F);
    push_op(5'h11, 9'd1);
    wait_done();
    push_op(5'h00, 9'd1); wait_done();
    chk("R5 op 0x11 byte", cap_q[0], 8'h0F);
    chk("R5 op 0x11 edges", rise_cnt, 8);
  endtask

  task automatic t_rx();
    logic [15:0] d;
    push_op(5'h01, 9'd1); wait_done();
    clr_mon();
    slv_sh = 16'h965A;
    push_op(5'h0C, 9'd2);
    wait_done();
    push_op(5'h00, 9'd1); wait_done();
    chk("R6 mosi high", cap_q[0], 8'hFF);
    rd(3'd5, d); chk("R6 rx byte0", d, 16'h96);
    wr(3'd6, 16'h1);
    rd(3'd5, d); chk("R6 rx byte1", d, 16'h5A);
    wr(3'd6, 16'h1);
    rd(3'd3, d); chk("R7 empty after pops", d, 16'hA);
  endtask

  task automatic t_unknown();
    logic [15:0] d;
    wr(3'd4, 16'h77);
    clr_mon();
    push_op(5'h07, 9'd3);
    push_op(5'h08, 9'd0);
    wait_done();
    chk("R10 no sclk", rise_cnt, 0);
    chk("R10 cs untouched", cs_n, 1);
    rd(3'd5, d); chk("R10 fifo untouched", d, 16'h77);
    wr(3'd6, 16'h1);
  endtask

  task automatic t_stall();
    logic [15:0] d;
    push_op(5'h01, 9'd1); wait_done();
    clr_mon();
    wr(3'd4, 16'h81);
    push_op(5'h08, 9'd2);
    repeat (12 * DIV + 20) @(negedge clk);
    chk("R11 stall edges", rise_cnt, 8);
    chk("R11 sclk low in stall", sclk, 0);
    rd(3'd3, d); chk("R11 busy in stall", d[1], 0);
    wr(3'd4, 16'h42);
    wait_done();
    push_op(5'h00, 9'd1); wait_done();
    chk("R11 resumed edges", rise_cnt, 16);
    chk("R11 resumed byte", cap_q[1], 8'h42);
  endtask

  task automatic t_opfull();
    logic [15:0] d;
    wr(3'd0, 16'h0);
    for (int i = 0; i < OPD + 1; i++) push_op(5'h08, 9'd1);
    rd(3'd3, d); chk("R2 op full", d, 16'h9);
    for (int i = 0; i < OPD + 1; i++) wr(3'd4, 16'(i + 1));
    clr_mon();
    wr(3'd0, 16'h1);
    wait_done();
    chk("R2 extra push dropped", rise_cnt, 8 * OPD);
    rd(3'd5, d); chk("R2 leftover byte", d, 16'(OPD + 1));
    wr(3'd6, 16'h1);
    rd(3'd3, d); chk("R8 all done", d, 16'hA);
  endtask

  task automatic t_datfull();
    logic [15:0] d;
    for (int i = 0; i < DD; i++) wr(3'd4, 16'(i + 16));
    rd(3'd3, d); chk("R7 data full", d, 16'h6);
    wr(3'd4, 16'hEE);
    for (int i = 0; i < DD; i++) begin
      rd(3'd5, d); chk("R7 fifo order", d, 16'(i + 16));
      wr(3'd6, 16'h1);
    end
    rd(3'd3, d); chk("R7 empty", d, 16'hA);
    wr(3'd6, 16'h1);
    wr(3'd4, 16'h33);
    rd(3'd5, d); chk("R7 pop on empty ignored", d, 16'h33);
    wr(3'd6, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_manual_gate();
    t_tx();
    t_tx_addr();
    t_rx();
    t_unknown();
    t_stall();
    t_opfull();
    t_datfull();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule